// File: doc/BRIEF.md
# SCSI Initiator Register and Interrupt Bank

This block is the host-facing byte register bank of a small SCSI initiator controller. A 4-bit address with separate single-cycle read and write strobes selects one of sixteen byte locations. Most locations hold two different registers: the host writes one and reads the other. The bank keeps the status, interrupt-cause and sequence-step registers and drives a level interrupt. It also holds a 16-entry byte FIFO that the host reaches through a single address.

A separate command decoder, outside this block, reports the outcome of each bus operation through a one-cycle update strobe. The strobe carries new status, interrupt-cause and sequence-step values and can optionally raise the interrupt. The host acknowledges by reading the interrupt-cause register. That read returns the pending cause and clears the condition in the same access. The command byte and the target ID written by the host are handed to the decoder on dedicated outputs.

Top module: `scsi_regbank`

## Requirements
- R1: After reset every readable location returns 0x00, except location 0xE, which returns the identification value 0x04, and location 8 (configuration 1), which returns 0x07. irq_o is low after reset.
- R2: Status bit 7 (read at location 4) always equals irq_o. An update strobe with upd_raise_i set drives irq_o high.
- R3: A read of location 5 returns the interrupt cause held before the read. The same read clears the cause to 0x00, clears status bit 4, sets the sequence step (location 6) to 0x04 and drops irq_o.
- R4: A write to location 0 or location 1 clears status bit 4 and leaves the other status bits unchanged.
- R5: A write to location 2 stores a byte in the FIFO unless 15 bytes are already held, in which case the byte is dropped. The FIFO byte count reads in bits [4:0] of location 7.
- R6: A read of location 2 with a non-zero count decrements the count and raises irq_o. If status bits [2:1] are not both zero, the read returns the oldest byte and advances to the next one. Otherwise it returns 0x00 and does not advance. A read with a zero count returns the value of the previous FIFO read and changes nothing.
- R7: When a FIFO read brings the count to zero, both FIFO pointers return to the first entry, so the next byte written is the next byte read.
- R8: Writes to location 8 and to locations 0xB to 0xF are read back unchanged. Writes to locations 4 to 7, 9 and 0xA do not change what those locations read. The last byte written to location 4 appears on busid_o.
- R9: A write to location 3 is read back at location 3. In the following cycle the byte appears on cmd_o with cmd_stb_o high for one cycle. If bit 7 of the command is set, locations 0 and 1 from then on read the bytes last written to them. Otherwise they keep their previous read value.
- R10: An update strobe loads status bits [6:0], the interrupt cause and the sequence step. When it coincides with a host read of location 5, the update values win over the clearing effects of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register location |
| wr_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Single-cycle read strobe; side effects happen only when it is high |
| rdata_o | output | 8 | Read data for addr_i, valid in the strobe cycle |
| upd_i | input | 1 | Update strobe from the command decoder |
| upd_stat_i | input | 7 | New status bits [6:0] |
| upd_intr_i | input | 8 | New interrupt cause |
| upd_seq_i | input | 8 | New sequence step |
| upd_raise_i | input | 1 | Raise the interrupt together with the update |
| irq_o | output | 1 | Level interrupt request |
| cmd_o | output | 8 | Last command byte written |
| cmd_stb_o | output | 1 | One-cycle pulse after a command write |
| busid_o | output | 8 | Last target ID byte written |

## Verification
The bench targets four corner cases.

- Acknowledge read: the bench checks the value returned and the state left behind when the interrupt-cause register is read. A bank that clears the cause before the read data is formed returns 0x00 instead of the pending cause.
- FIFO at the 15-byte limit: the bench fills the FIFO and writes once more. A design that accepts a sixteenth byte overwrites data and shows the wrong count.
- FIFO reads with a zero transfer phase: the bench reads while status bits [2:1] are both zero. A design that advances the read pointer here hands later reads the wrong byte. After such reads empty the FIFO, a design that forgets to rewind its pointers returns stale data.
- Ordering: the bench checks the update strobe that coincides with an acknowledge read, and checks that a command without bit 7 does not reload the counter. Random traffic under a fixed seed then mixes all of these.

// File: rtl/scsi_rb_pkg.sv
package scsi_rb_pkg;
  localparam int unsigned REG_N  = 16;
  localparam int unsigned ADDR_W = 4;

  localparam logic [3:0] A_TCLO  = 4'h0;
  localparam logic [3:0] A_TCMID = 4'h1;
  localparam logic [3:0] A_FIFO  = 4'h2;
  localparam logic [3:0] A_CMD   = 4'h3;
  localparam logic [3:0] A_STAT  = 4'h4;
  localparam logic [3:0] A_INTR  = 4'h5;
  localparam logic [3:0] A_SEQ   = 4'h6;
  localparam logic [3:0] A_FLAGS = 4'h7;
  localparam logic [3:0] A_CFG1  = 4'h8;
  localparam logic [3:0] A_TCHI  = 4'hE;

  localparam logic [7:0] ID_VALUE    = 8'h04;
  localparam logic [7:0] CFG1_RESET  = 8'h07;
  localparam logic [7:0] SEQ_ACK     = 8'h04;
  localparam int unsigned TC_BIT     = 4;
  localparam int unsigned CMD_DMA_BIT = 7;

  // read side follows host writes at these locations
  function automatic logic is_mirrored(input logic [3:0] a);
    return (a == A_CFG1) || (a >= 4'hB);
  endfunction

  function automatic logic [7:0] mirror_reset(input logic [3:0] a);
    if (a == A_CFG1) return CFG1_RESET;
    if (a == A_TCHI) return ID_VALUE;
    return 8'h00;
  endfunction
endpackage

// File: rtl/rb_status.sv
module rb_status
  import scsi_rb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_rd_i,
  input  logic       tc_clr_i,
  input  logic       fifo_raise_i,
  input  logic       upd_i,
  input  logic [6:0] upd_stat_i,
  input  logic [7:0] upd_intr_i,
  input  logic [7:0] upd_seq_i,
  input  logic       upd_raise_i,
  output logic [7:0] status_o,
  output logic [7:0] intr_o,
  output logic [7:0] seq_o,
  output logic       irq_o
);
  logic [6:0] stat_q;
  logic [7:0] intr_q, seq_q;
  logic       irq_q;

  // later statements win: host effects first, decoder update last
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      intr_q <= '0;
      seq_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ack_rd_i) begin
        intr_q         <= '0;
        seq_q          <= SEQ_ACK;
        irq_q          <= 1'b0;
        stat_q[TC_BIT] <= 1'b0;
      end
      if (tc_clr_i)     stat_q[TC_BIT] <= 1'b0;
      if (fifo_raise_i) irq_q <= 1'b1;
      if (upd_i) begin
        stat_q <= upd_stat_i;
        intr_q <= upd_intr_i;
        seq_q  <= upd_seq_i;
        if (upd_raise_i) irq_q <= 1'b1;
      end
    end
  end

  assign status_o = {irq_q, stat_q};
  assign intr_o   = intr_q;
  assign seq_o    = seq_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/rb_fifo.sv
module rb_fifo #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [7:0]    din_i,
  input  logic          pop_i,
  input  logic          deliver_i,
  output logic [7:0]    dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          pop_ok_o
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 1);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    last_q, head;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != LIMIT);
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign head    = deliver_i ? mem_q[rptr_q] : 8'h00;

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok) cnt_d = cnt_d + 1'b1;
    if (pop_ok)  cnt_d = cnt_d - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (push_ok) begin
        mem_q[wptr_q] <= din_i;
        wptr_q        <= wptr_q + 1'b1;
      end
      if (pop_ok) begin
        last_q <= head;
        if (deliver_i) rptr_q <= rptr_q + 1'b1;
        if (cnt_d == '0) begin
          rptr_q <= '0;
          wptr_q <= '0;
        end
      end
    end
  end

  assign dout_o   = (cnt_q != '0) ? head : last_q;
  assign cnt_o    = cnt_q;
  assign pop_ok_o = pop_ok;
endmodule

// File: rtl/rb_cfgbank.sv
module rb_cfgbank
  import scsi_rb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rd_o
);
  logic [7:0] bank [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_loc
    if (is_mirrored(4'(g))) begin : g_mir
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            bank[g] <= mirror_reset(4'(g));
        else if (wr_i && addr_i == 4'(g))       bank[g] <= wdata_i;
      end
    end else begin : g_none
      assign bank[g] = 8'h00;
    end
  end

  assign rd_o = bank[addr_i];
endmodule

// File: rtl/scsi_regbank.sv
module scsi_regbank
  import scsi_rb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  input  logic       upd_i,
  input  logic [6:0] upd_stat_i,
  input  logic [7:0] upd_intr_i,
  input  logic [7:0] upd_seq_i,
  input  logic       upd_raise_i,
  output logic       irq_o,
  output logic [7:0] cmd_o,
  output logic       cmd_stb_o,
  output logic [7:0] busid_o
);
  logic [7:0]    status_q, intr_q, seq_q, fifo_dout, cfg_rd;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_pop_ok;
  logic [7:0]    tcw_lo_q, tcw_mid_q, tcr_lo_q, tcr_mid_q, cmd_q, busid_q;
  logic          cmd_stb_q;

  logic ack_rd, tc_clr, cmd_wr;
  assign ack_rd = rd_i && (addr_i == A_INTR);
  assign tc_clr = wr_i && ((addr_i == A_TCLO) || (addr_i == A_TCMID));
  assign cmd_wr = wr_i && (addr_i == A_CMD);

  rb_status u_stat (
    .clk_i, .rst_ni,
    .ack_rd_i    (ack_rd),
    .tc_clr_i    (tc_clr),
    .fifo_raise_i(fifo_pop_ok),
    .upd_i, .upd_stat_i, .upd_intr_i, .upd_seq_i, .upd_raise_i,
    .status_o    (status_q),
    .intr_o      (intr_q),
    .seq_o       (seq_q),
    .irq_o       (irq_o)
  );

  rb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i   (wr_i && (addr_i == A_FIFO)),
    .din_i    (wdata_i),
    .pop_i    (rd_i && (addr_i == A_FIFO)),
    .deliver_i(status_q[2:1] != 2'b00),
    .dout_o   (fifo_dout),
    .cnt_o    (fifo_cnt),
    .pop_ok_o (fifo_pop_ok)
  );

  rb_cfgbank u_cfg (
    .clk_i, .rst_ni,
    .wr_i, .addr_i, .wdata_i,
    .rd_o(cfg_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcw_lo_q  <= '0;
      tcw_mid_q <= '0;
      tcr_lo_q  <= '0;
      tcr_mid_q <= '0;
      cmd_q     <= '0;
      busid_q   <= '0;
      cmd_stb_q <= 1'b0;
    end else begin
      cmd_stb_q <= cmd_wr;
      if (wr_i && addr_i == A_TCLO)  tcw_lo_q  <= wdata_i;
      if (wr_i && addr_i == A_TCMID) tcw_mid_q <= wdata_i;
      if (wr_i && addr_i == A_STAT)  busid_q   <= wdata_i;
      if (cmd_wr) begin
        cmd_q <= wdata_i;
        if (wdata_i[CMD_DMA_BIT]) begin
          tcr_lo_q  <= tcw_lo_q;
          tcr_mid_q <= tcw_mid_q;
        end
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_TCLO:  rdata_o = tcr_lo_q;
      A_TCMID: rdata_o = tcr_mid_q;
      A_FIFO:  rdata_o = fifo_dout;
      A_CMD:   rdata_o = cmd_q;
      A_STAT:  rdata_o = status_q;
      A_INTR:  rdata_o = intr_q;
      A_SEQ:   rdata_o = seq_q;
      A_FLAGS: rdata_o = 8'(fifo_cnt);
      default: rdata_o = cfg_rd;
    endcase
  end

  assign cmd_o     = cmd_q;
  assign cmd_stb_o = cmd_stb_q;
  assign busid_o   = busid_q;
endmodule

// File: rtl/scsi_regbank_chk.sv
module scsi_regbank_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          upd_i,
  input logic          upd_raise_i,
  input logic          irq_o,
  input logic [7:0]    status_q,
  input logic [7:0]    intr_q,
  input logic [7:0]    seq_q,
  input logic [CW-1:0] fifo_cnt
);
  // R3
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'h5 && !upd_i) |=>
      (!irq_o && seq_q == 8'h04 && intr_q == 8'h00 && !status_q[4]));

  // R2
  upd_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_raise_i) |=> irq_o);

  // R4
  tc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i <= 4'h1 && !upd_i) |=> !status_q[4]);

  // R5
  fifo_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == 4'h2 && fifo_cnt == CW'(DEPTH - 1)) |=> $stable(fifo_cnt));

  // R5
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH - 1));

  // R6
  fifo_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == 4'h2 && fifo_cnt != '0) |=>
      (irq_o && fifo_cnt == $past(fifo_cnt) - 1'b1));
endmodule

bind scsi_regbank scsi_regbank_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .upd_i      (upd_i),
  .upd_raise_i(upd_raise_i),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .intr_q     (intr_q),
  .seq_q      (seq_q),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/scsi_regbank_test.sv
`timescale 1ns/1ps
module scsi_regbank_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, upd = 1'b0, upd_raise = 1'b0;
  logic [7:0] wdata = '0, upd_intr = '0, upd_seq = '0;
  logic [6:0] upd_stat = '0;
  logic [7:0] rdata, cmd, busid;
  logic       irq, cmd_stb;

  always #10 clk = ~clk;

  scsi_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .upd_i(upd), .upd_stat_i(upd_stat),
    .upd_intr_i(upd_intr), .upd_seq_i(upd_seq), .upd_raise_i(upd_raise),
    .irq_o(irq), .cmd_o(cmd), .cmd_stb_o(cmd_stb), .busid_o(busid)
  );

  int ncmp = 0, nbad = 0;
  bit done = 0;

  // reference model state
  logic [6:0] m_stat = '0;
  logic       m_irq = 0;
  logic [7:0] m_intr = '0, m_seq = '0, m_last = '0, m_cmd = '0;
  logic [7:0] m_mem [16];
  int         m_wp = 0, m_rp = 0, m_cnt = 0;
  logic [7:0] m_tcw [2], m_tcr [2], m_mir [16];

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    ncmp++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'h0, 4'h1, 4'h3: return "R9";
      4'h2:             return "R6";
      4'h4:             return "R2";
      4'h5, 4'h6:       return "R3";
      4'h7:             return "R5";
      default:          return "R8";
    endcase
  endfunction

  task automatic m_read(input logic [3:0] a, output logic [7:0] v);
    case (a)
      4'h0: v = m_tcr[0];
      4'h1: v = m_tcr[1];
      4'h2: begin
        if (m_cnt != 0) begin
          v = (m_stat[2:1] != 0) ? m_mem[m_rp] : 8'h00;
          m_last = v;
          if (m_stat[2:1] != 0) m_rp = (m_rp + 1) % 16;
          m_cnt--;
          if (m_cnt == 0) begin m_rp = 0; m_wp = 0; end
          m_irq = 1;
        end else v = m_last;
      end
      4'h3: v = m_cmd;
      4'h4: v = {m_irq, m_stat};
      4'h5: begin v = m_intr; m_intr = 0; m_stat[4] = 0; m_seq = 8'h04; m_irq = 0; end
      4'h6: v = m_seq;
      4'h7: v = 8'(m_cnt);
      4'h9, 4'hA: v = 8'h00;
      default: v = m_mir[a];
    endcase
  endtask

  task automatic m_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'h0, 4'h1: begin m_tcw[a[0]] = d; m_stat[4] = 0; end
      4'h2: if (m_cnt != 15) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % 16; m_cnt++; end
      4'h3: begin m_cmd = d; if (d[7]) begin m_tcr[0] = m_tcw[0]; m_tcr[1] = m_tcw[1]; end end
      4'h8, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: m_mir[a] = d;
      default: ;
    endcase
  endtask

  task automatic op_rd(input logic [3:0] a, input string tag);
    logic [7:0] got, exp;
    @(negedge clk); addr = a; rd = 1;
    #5 got = rdata;
    m_read(a, exp);
    @(negedge clk); rd = 0;
    chk(tag, got, exp);
    chk("R2 irq", {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic op_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
    m_write(a, d);
    if (a == 4'h3) begin
      chk("R9 stb", {7'd0, cmd_stb}, 8'h01);
      chk("R9 cmd_o", cmd, d);
    end
    if (a == 4'h4) chk("R8 busid", busid, d);
    chk("R2 irq", {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic op_upd(input logic [6:0] s, input logic [7:0] i, input logic [7:0] q,
                        input logic r, input bit ack);
    logic [7:0] got, exp;
    @(negedge clk);
    upd = 1; upd_stat = s; upd_intr = i; upd_seq = q; upd_raise = r;
    if (ack) begin addr = 4'h5; rd = 1; end
    #5 got = rdata;
    if (ack) m_read(4'h5, exp);
    m_stat = s; m_intr = i; m_seq = q; if (r) m_irq = 1;
    @(negedge clk); upd = 0; rd = 0; upd_raise = 0;
    if (ack) chk("R10 ack value", got, exp);
    chk("R2 irq", {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      ncmp++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin m_mem[i] = 0; m_mir[i] = 0; end
    m_tcw[0] = 0; m_tcw[1] = 0; m_tcr[0] = 0; m_tcr[1] = 0;
    m_mir[8] = 8'h07; m_mir[14] = 8'h04;
    void'($urandom(32'h1F3A));
    #45 rst_n = 1;

    // R1: reset values
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 16; a++) op_rd(4'(a), "R1");

    // R5: fill past the limit
    for (int i = 0; i < 17; i++) op_wr(4'h2, 8'(8'h30 + i));
    op_rd(4'h7, "R5 count");
    chk("R5 literal", 8'(m_cnt), 8'd15);

    // R6: drain in order with a data phase
    op_upd(7'h02, 8'h00, 8'h00, 1'b0, 1'b0);
    op_rd(4'h2, "R6 first");
    chk("R6 first byte", m_last, 8'h30);
    while (m_cnt != 0) op_rd(4'h2, "R6 drain");
    op_rd(4'h2, "R6 empty read");

    // R7: zero-phase reads then pointer rewind
    op_wr(4'h2, 8'hAA); op_wr(4'h2, 8'hBB);
    op_upd(7'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    op_rd(4'h2, "R6 zero phase"); op_rd(4'h2, "R6 zero phase");
    op_upd(7'h02, 8'h00, 8'h00, 1'b0, 1'b0);
    op_wr(4'h2, 8'hCC);
    op_rd(4'h2, "R7 rewind");
    chk("R7 literal", m_last, 8'hCC);

    // R3: acknowledge read
    op_upd(7'h13, 8'h18, 8'h02, 1'b1, 1'b0);
    op_rd(4'h4, "R2 status");
    op_rd(4'h5, "R3 ack");
    op_rd(4'h4, "R3 status after");
    op_rd(4'h6, "R3 seq");
    op_rd(4'h5, "R3 cleared");

    // R4
    op_upd(7'h17, 8'h00, 8'h00, 1'b0, 1'b0);
    op_wr(4'h0, 8'h5A);
    op_rd(4'h4, "R4 after lo");
    op_upd(7'h10, 8'h00, 8'h00, 1'b0, 1'b0);
    op_wr(4'h1, 8'hA5);
    op_rd(4'h4, "R4 after mid");

    // R9: non-DMA command keeps counter, DMA command loads it
    op_wr(4'h3, 8'h10);
    op_rd(4'h0, "R9 no load"); op_rd(4'h3, "R9 cmd");
    op_wr(4'h3, 8'h90);
    op_rd(4'h0, "R9 lo"); op_rd(4'h1, "R9 mid");

    // R8
    op_wr(4'h9, 8'h77); op_rd(4'h9, "R8 shadow only");
    op_wr(4'h5, 8'h66); op_rd(4'h5, "R8 intr untouched");
    op_wr(4'h4, 8'h03); op_wr(4'hB, 8'h42); op_rd(4'hB, "R8 mirror");

    // R10: update collides with acknowledge
    op_upd(7'h01, 8'h28, 8'h03, 1'b1, 1'b0);
    op_upd(7'h05, 8'h08, 8'h01, 1'b1, 1'b1);
    op_rd(4'h5, "R10 intr"); op_rd(4'h6, "R10 seq");

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      int r;
      logic [3:0] a;
      r = int'($urandom % 16);
      a = 4'($urandom);
      if (r < 5)       op_wr(4'h2, 8'($urandom));
      else if (r < 8)  op_rd(4'h2, "R6 rand");
      else if (r == 8) op_upd(7'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
      else if (r == 9) op_rd(4'h5, "R3 rand");
      else if (r < 12) op_rd(a, tag_of(a));
      else if (r < 14) op_wr(a, 8'($urandom));
      else if (r == 14) op_wr(4'(r % 2), 8'($urandom));
      else op_rd(4'h4, "R4 rand");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule